// File: doc/BRIEF.md
# Interrupt Acknowledge and Reset Sequencer

This block sits between a CPU core and two external control pins: an interrupt request line and a reset line. It runs on the CPU step clock. An interrupt request arrives as a single-cycle high pulse. The block latches it as pending, so that a short pulse cannot be lost. The block then waits until the core reports that it is ready. At that point it raises an acknowledge strobe for exactly two cycles. Nothing is transferred in the first strobe cycle. In the second strobe cycle a peer places a vector byte on the 8-bit I/O bus. The block captures that byte at the edge that closes the cycle and hands it to the core with a one-cycle valid pulse.

The reset pin is sampled on each rising clock edge. Every edge that sees the pin high produces one cycle of reset request to the core. A pin held high therefore re-applies reset on every clock. The load address presented with the request is always the reset vector, 0xFFFE. A pin reset outranks interrupt handling: it aborts an acknowledge in progress, drops the pending request and blocks any capture.

The block has a separate asynchronous active-low reset. It asserts immediately and is released through a synchronizer.

Top module: `ias_seq`

## Requirements
- R1: While rst_n is low and until it has been released, ack_out, irq_pending, vec_valid and rst_req are 0 and vec_data is 0x00; rst_addr always reads 0xFFFE.
- R2: If irq_pin is high at a rising edge while irq_enable is high, irq_pending is 1 from the next cycle. It stays 1, whatever irq_pin does, until the acknowledge completes.
- R3: When the block is idle and sees irq_pending and core_ready high at an edge, ack_out is high for exactly the two cycles that follow that edge.
- R4: The byte on io_bus during the first acknowledge cycle is not captured: vec_valid stays 0 and vec_data keeps its previous value.
- R5: The byte on io_bus during the second acknowledge cycle is captured at the edge closing that cycle. From then on vec_data holds it and vec_valid is 1 for exactly one cycle. irq_pending clears at that same edge.
- R6: A request on irq_pin while irq_enable is low is ignored: irq_pending stays 0.
- R7: When rst_pin is high at a rising edge, rst_req is 1 for the following cycle. When rst_pin is low at the edge, rst_req is 0 for the following cycle.
- R8: If rst_pin stays high across N consecutive edges, rst_req is 1 for N consecutive cycles.
- R9: An edge that sees rst_pin high ends any acknowledge: ack_out is 0 afterwards and irq_pending is cleared. No vector is captured, even at the closing edge of the second cycle. A request on irq_pin at that same edge is dropped.
- R10: A request sampled at the edge that completes an acknowledge leaves irq_pending at 1.
- R11: While core_ready is low, a pending request waits and ack_out stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU step clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| irq_pin | input | 1 | External interrupt request pulse |
| irq_enable | input | 1 | Allows new requests to be latched |
| core_ready | input | 1 | Core can service an interrupt now |
| rst_pin | input | 1 | External reset pin, sampled each edge |
| io_bus | input | 8 | Byte-wide I/O bus carrying the vector |
| ack_out | output | 1 | Interrupt acknowledge strobe |
| irq_pending | output | 1 | A latched request awaits service |
| vec_data | output | 8 | Last captured vector byte |
| vec_valid | output | 1 | One-cycle pulse marking a new vector |
| rst_req | output | 1 | Reset request to the core |
| rst_addr | output | 16 | Load address for the program counter on reset |

## Verification
The collision that matters is a pin reset at the very edge that would close the second acknowledge cycle. At that edge a capture and a reset fall in the same cycle. The bench provokes it by driving a recognisable byte on io_bus during the second strobe cycle while raising rst_pin and a fresh irq_pin pulse for that same edge. The bench judges the outcome at the ports. rst_req must rise. ack_out and irq_pending must drop. vec_valid must stay low. The scoreboard must receive no vector.

// File: rtl/ias_pkg.sv
package ias_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_FIRST  = 2'd1,
    ACK_SECOND = 2'd2
  } ack_state_e;
endpackage

// File: rtl/ias_rst_sync.sv
module ias_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ias_req_latch.sv
module ias_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic req_en,
  input  logic done,
  input  logic abort,
  output logic pending
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (abort)                 pend_d = 1'b0;
    else if (req_in && req_en) pend_d = 1'b1;  // new request wins over completion
    else if (done)             pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;
endmodule

// File: rtl/ias_ack_fsm.sv
module ias_ack_fsm
  import ias_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic ready,
  input  logic abort,
  output logic ack,
  output logic capture
);
  ack_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACK_IDLE:   if (pending && ready) state_d = ACK_FIRST;
      ACK_FIRST:  state_d = ACK_SECOND;
      ACK_SECOND: state_d = ACK_IDLE;
      default:    state_d = ACK_IDLE;
    endcase
    if (abort) state_d = ACK_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ACK_IDLE;
    else        state_q <= state_d;
  end

  assign ack     = (state_q != ACK_IDLE);
  assign capture = (state_q == ACK_SECOND) && !abort;
endmodule

// File: rtl/ias_vec_capture.sv
module ias_vec_capture #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [VEC_W-1:0] bus,
  output logic [VEC_W-1:0] vec,
  output logic             valid
);
  logic [VEC_W-1:0] vec_q;
  logic             valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vec_q <= '0;
    else if (capture) vec_q <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= capture;
  end

  assign vec   = vec_q;
  assign valid = valid_q;
endmodule

// File: rtl/ias_reset_sampler.sv
module ias_reset_sampler #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] RESET_VEC = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin,
  output logic              req,
  output logic [ADDR_W-1:0] addr
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= pin;
  end

  assign req  = req_q;
  assign addr = ADDR_W'(RESET_VEC);
endmodule

// File: rtl/ias_seq.sv
module ias_seq #(
  parameter int          VEC_W       = 8,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] RESET_VEC   = 16'hFFFE,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pin,
  input  logic              irq_enable,
  input  logic              core_ready,
  input  logic              rst_pin,
  input  logic [VEC_W-1:0]  io_bus,
  output logic              ack_out,
  output logic              irq_pending,
  output logic [VEC_W-1:0]  vec_data,
  output logic              vec_valid,
  output logic              rst_req,
  output logic [ADDR_W-1:0] rst_addr
);
  logic rst_sync_n;
  logic capture;

  ias_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ias_req_latch u_req (
    .clk(clk), .rst_n(rst_sync_n), .req_in(irq_pin), .req_en(irq_enable),
    .done(capture), .abort(rst_pin), .pending(irq_pending)
  );

  ias_ack_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .pending(irq_pending), .ready(core_ready),
    .abort(rst_pin), .ack(ack_out), .capture(capture)
  );

  ias_vec_capture #(.VEC_W(VEC_W)) u_vec (
    .clk(clk), .rst_n(rst_sync_n), .capture(capture), .bus(io_bus),
    .vec(vec_data), .valid(vec_valid)
  );

  ias_reset_sampler #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_rst (
    .clk(clk), .rst_n(rst_sync_n), .pin(rst_pin), .req(rst_req), .addr(rst_addr)
  );
endmodule

// File: rtl/ias_seq_chk.sv
module ias_seq_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic irq_enable,
  input logic rst_pin,
  input logic ack_out,
  input logic irq_pending,
  input logic vec_valid,
  input logic rst_req
);
  AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(ack_out) && !rst_pin) |=> ack_out);  // R3

  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ack_out && $past(ack_out)) |=> !ack_out);  // R3

  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_valid |-> ($past(ack_out, 1) && $past(ack_out, 2) && !ack_out));  // R5

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_valid |=> !vec_valid);  // R5

  AST_NO_LATCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!irq_pending && !irq_enable) |=> !irq_pending);  // R6

  AST_PIN_RESET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_pin |=> (rst_req && !irq_pending && !ack_out && !vec_valid));  // R9

  AST_PIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rst_pin |=> !rst_req);  // R7
endmodule

bind ias_seq ias_seq_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .irq_enable(irq_enable), .rst_pin(rst_pin),
  .ack_out(ack_out), .irq_pending(irq_pending), .vec_valid(vec_valid), .rst_req(rst_req)
);

// File: tb/ias_seq_tb.sv
module ias_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, irq_pin, irq_enable, core_ready, rst_pin;
  logic [7:0]  io_bus;
  logic        ack_out, irq_pending, vec_valid, rst_req;
  logic [7:0]  vec_data;
  logic [15:0] rst_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ias_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .irq_enable(irq_enable),
    .core_ready(core_ready), .rst_pin(rst_pin), .io_bus(io_bus),
    .ack_out(ack_out), .irq_pending(irq_pending), .vec_data(vec_data),
    .vec_valid(vec_valid), .rst_req(rst_req), .rst_addr(rst_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Scoreboard monitor: each vector pulse must match the oldest expected byte.
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R5/R9: actual vector %0h expected none", vec_data);
      end else begin
        check("R5 scoreboard vector", {24'h0, vec_data}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_pin = 1'b0; irq_enable = 1'b0; core_ready = 1'b0;
    rst_pin = 1'b0; io_bus = 8'h00;
    repeat (3) cyc();
    check("R1 ack in reset", {31'h0, ack_out}, 32'h0);
    check("R1 rst_addr", {16'h0, rst_addr}, 32'hFFFE);
    rst_n = 1'b1;
    repeat (4) cyc();
    check("R1 pending", {31'h0, irq_pending}, 32'h0);
    check("R1 valid", {31'h0, vec_valid}, 32'h0);
    check("R1 rst_req", {31'h0, rst_req}, 32'h0);
    check("R1 vec_data", {24'h0, vec_data}, 32'h0);

    // R6: disabled request ignored
    irq_pin = 1'b1; cyc(); irq_pin = 1'b0;
    check("R6 disabled request", {31'h0, irq_pending}, 32'h0);
    cyc();
    check("R6 disabled request later", {31'h0, irq_pending}, 32'h0);

    // R2 / R11: latch and wait
    irq_enable = 1'b1;
    irq_pin = 1'b1; cyc(); irq_pin = 1'b0;
    check("R2 pending set", {31'h0, irq_pending}, 32'h1);
    repeat (3) cyc();
    check("R2 pending held", {31'h0, irq_pending}, 32'h1);
    check("R11 no ack while not ready", {31'h0, ack_out}, 32'h0);

    // R3 / R4 / R5: full acknowledge
    core_ready = 1'b1; cyc();
    check("R3 ack first cycle", {31'h0, ack_out}, 32'h1);
    core_ready = 1'b0; io_bus = 8'h5A; cyc();
    check("R3 ack second cycle", {31'h0, ack_out}, 32'h1);
    check("R4 no capture in first cycle", {31'h0, vec_valid}, 32'h0);
    check("R4 vec_data unchanged", {24'h0, vec_data}, 32'h0);
    io_bus = 8'hA7; exp_q.push_back(8'hA7); cyc();
    check("R3 ack ends", {31'h0, ack_out}, 32'h0);
    check("R5 valid", {31'h0, vec_valid}, 32'h1);
    check("R5 data", {24'h0, vec_data}, 32'hA7);
    check("R5 pending cleared", {31'h0, irq_pending}, 32'h0);
    io_bus = 8'h00; cyc();
    check("R5 valid one cycle", {31'h0, vec_valid}, 32'h0);
    check("R5 data held", {24'h0, vec_data}, 32'hA7);

    // R7 / R8: reset pin sampling
    rst_pin = 1'b1; cyc(); rst_pin = 1'b0;
    check("R7 rst_req single", {31'h0, rst_req}, 32'h1);
    cyc();
    check("R7 rst_req drops", {31'h0, rst_req}, 32'h0);
    rst_pin = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cyc();
      check("R8 rst_req held", {31'h0, rst_req}, 32'h1);
    end
    rst_pin = 1'b0; cyc();
    check("R8 rst_req released", {31'h0, rst_req}, 32'h0);
    check("R1 rst_addr after reset", {16'h0, rst_addr}, 32'hFFFE);

    // R10: request on completing edge stays pending
    irq_pin = 1'b1; cyc(); irq_pin = 1'b0; core_ready = 1'b1; cyc();
    core_ready = 1'b0; cyc();
    io_bus = 8'h3C; exp_q.push_back(8'h3C); irq_pin = 1'b1; cyc(); irq_pin = 1'b0;
    check("R10 pending kept", {31'h0, irq_pending}, 32'h1);
    check("R10 vector", {24'h0, vec_data}, 32'h3C);
    core_ready = 1'b1; cyc();
    check("R10 second ack", {31'h0, ack_out}, 32'h1);
    core_ready = 1'b0; cyc();
    io_bus = 8'hC3; exp_q.push_back(8'hC3); cyc();
    check("R10 second vector", {24'h0, vec_data}, 32'hC3);
    check("R10 pending cleared", {31'h0, irq_pending}, 32'h0);

    // R9: reset at the capture edge with a new request
    irq_pin = 1'b1; cyc(); irq_pin = 1'b0; core_ready = 1'b1; cyc();
    core_ready = 1'b0; cyc();
    check("R9 in second ack cycle", {31'h0, ack_out}, 32'h1);
    io_bus = 8'h99; rst_pin = 1'b1; irq_pin = 1'b1; cyc();
    rst_pin = 1'b0; irq_pin = 1'b0;
    check("R9 rst_req", {31'h0, rst_req}, 32'h1);
    check("R9 ack dropped", {31'h0, ack_out}, 32'h0);
    check("R9 pending cleared", {31'h0, irq_pending}, 32'h0);
    check("R9 no capture", {31'h0, vec_valid}, 32'h0);
    check("R9 vec_data kept", {24'h0, vec_data}, 32'hC3);
    cyc();
    check("R9 no late vector", {31'h0, vec_valid}, 32'h0);
    check("R9 pending stays clear", {31'h0, irq_pending}, 32'h0);

    repeat (3) cyc();
    check("R5 scoreboard drained", exp_q.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule